// File: doc/BRIEF.md
# Transceiver Direction Reset Sequencer

This block sequences the reset of one data direction (transmit or receive) of a group of serial transceiver channels. It offers two ways in. A full request first holds every PLL that clocks the direction in reset, then waits for all of them to lock. After that it pulses the datapath resets of every channel. A datapath-only request skips the PLL part and goes straight to the datapath resets. Both ways end in the same tail: the block waits until every channel reports that its reset has finished, then raises a completion flag.

The request inputs may arrive from any clock domain. Each one is synchronized into the free-running control clock and edge-detected, so a level held for many cycles counts as one request. A request that arrives while a sequence is running restarts the sequence at that request's entry point. The completion flag is carried into the direction's user clock through a two-flop synchronizer. A parameter selects the transmit variant. In that variant the programmable clock dividers of every channel are reset together with the datapath.

Top module: `xrs_dir_reset`

## Requirements
- R1: Each request input passes through a two-flop synchronizer and is edge-detected, so a request held high for any length of time starts exactly one sequence.
- R2: A full request drives every bit of `pll_rst_o` high for exactly `PLL_HOLD` consecutive control-clock cycles.
- R3: After the PLL hold, the datapath resets are not asserted while any bit of `pll_lock_i` is low.
- R4: If the locks are not all high within `LOCK_WAIT` cycles after the PLL hold, the PLL reset is applied again for another full hold.
- R5: A datapath-only request never asserts `pll_rst_o`, and it holds `dp_rst_o` high on every channel for exactly `DP_HOLD` cycles.
- R6: With `IS_TX`=1, each `div_rst_o` bit equals the matching `dp_rst_o` bit. With `IS_TX`=0, `div_rst_o` stays all zero.
- R7: `done_o` rises only after every bit of `ch_rst_done_i` is high, and it stays low while any channel has not finished.
- R8: An accepted request clears completion at once in the control domain. It restarts the sequence at that request's entry state, even in the middle of a sequence.
- R9: `done_o` is produced by two flops clocked by `usr_clk`. It follows the control-domain completion within three user-clock edges.
- R10: While `rst_n` is low, and after release until the first request, all outputs are zero.
- R11: If both requests are accepted in the same cycle, the full (PLL) request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_full_i | input | 1 | Request: PLL reset, then datapath reset (asynchronous level or pulse) |
| req_dp_i | input | 1 | Request: datapath-only reset (asynchronous level or pulse) |
| pll_lock_i | input | NUM_PLL | Lock indication of each PLL that clocks this direction |
| ch_rst_done_i | input | NUM_CH | Per-channel reset-finished indication |
| pll_rst_o | output | NUM_PLL | PLL reset, one bit per PLL |
| dp_rst_o | output | NUM_CH | Per-channel datapath reset |
| div_rst_o | output | NUM_CH | Per-channel programmable divider reset (transmit variant only) |
| usr_clk | input | 1 | User clock of the direction's master channel |
| done_o | output | 1 | Sequence complete, synchronous to `usr_clk` |

## Verification
The assertions check on every cycle the invariants that one cycle of the controller can show. Requests become single-cycle pulses, and the PLL hold runs exactly its length. The datapath reset never follows an unlocked wait, and a lock timeout goes back to the PLL reset. Completion never comes from an unfinished channel, and any accepted request clears completion and gives the full entry priority. The bench's scenarios cover what needs a whole sequence or a second clock. They count PLL retries after a given number of failed lock attempts, hold one channel back to stall completion, and restart in the middle of a sequence. They also measure how long the done flag takes to cross into the slower user clock and check that the receive variant never touches the dividers.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PLL_RST,
    S_WAIT_LOCK,
    S_DP_RST,
    S_WAIT_DP_DONE,
    S_DONE
  } seq_state_e;

  // Width of a counter able to hold values up to the largest limit.
  function automatic int unsigned cnt_bits(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return $clog2(m + 1) + 1;
  endfunction

  // True on the last cycle of a window of 'limit' cycles counted from zero.
  function automatic logic window_end(int unsigned cnt, int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

endpackage

// File: rtl/xrs_req_sync.sv
module xrs_req_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic req_pulse
);
  // [0],[1]: synchronizer, [2]: previous value for edge detection
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], req_async};
  end

  assign req_pulse = sh[1] & ~sh[2];

  // R1: a request produces single-cycle pulses only
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> !req_pulse);
endmodule

// File: rtl/xrs_seq_fsm.sv
module xrs_seq_fsm
  import xrs_pkg::*;
#(
  parameter int unsigned PLL_HOLD  = 8,
  parameter int unsigned LOCK_WAIT = 16,
  parameter int unsigned DP_HOLD   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_full,
  input  logic       go_dp,
  input  logic       lock_all,
  input  logic       ch_all_done,
  output seq_state_e state,
  output logic       pll_rst,
  output logic       dp_rst,
  output logic       done_ctrl
);
  localparam int unsigned CW = cnt_bits(PLL_HOLD, LOCK_WAIT, DP_HOLD);

  seq_state_e     nxt;
  logic [CW-1:0]  cnt, cnt_nxt;
  logic           go_any;

  assign go_any = go_full | go_dp;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt + 1'b1;
    if (go_full) begin
      nxt = S_PLL_RST;  cnt_nxt = '0;
    end else if (go_dp) begin
      nxt = S_DP_RST;   cnt_nxt = '0;
    end else begin
      unique case (state)
        S_IDLE: cnt_nxt = '0;
        S_PLL_RST:
          if (window_end(32'(cnt), PLL_HOLD)) begin
            nxt = S_WAIT_LOCK; cnt_nxt = '0;
          end
        S_WAIT_LOCK:
          if (lock_all) begin
            nxt = S_DP_RST; cnt_nxt = '0;
          end else if (window_end(32'(cnt), LOCK_WAIT)) begin
            nxt = S_PLL_RST; cnt_nxt = '0;
          end
        S_DP_RST:
          if (window_end(32'(cnt), DP_HOLD)) begin
            nxt = S_WAIT_DP_DONE; cnt_nxt = '0;
          end
        S_WAIT_DP_DONE: begin
          cnt_nxt = '0;
          if (ch_all_done) nxt = S_DONE;
        end
        S_DONE: cnt_nxt = '0;
        default: begin
          nxt = S_IDLE; cnt_nxt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
    end
  end

  assign pll_rst   = (state == S_PLL_RST);
  assign dp_rst    = (state == S_DP_RST);
  assign done_ctrl = (state == S_DONE);

  // ---------------- checker counters and assertions ----------------
  logic [CW-1:0] chk_hold, chk_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_hold <= '0;
      chk_wait <= '0;
    end else begin
      chk_hold <= (pll_rst && !go_full) ? chk_hold + 1'b1 : '0;
      chk_wait <= (state == S_WAIT_LOCK && !go_any) ? chk_wait + 1'b1 : '0;
    end
  end

  // R2: an uninterrupted PLL hold lasts exactly PLL_HOLD cycles
  a_r2_pll_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_rst && !go_any && chk_hold == CW'(PLL_HOLD - 1)) |=> !pll_rst);
  a_r2_pll_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_rst && !go_any && chk_hold < CW'(PLL_HOLD - 1)) |=> pll_rst);

  // R3: no datapath reset straight out of an unlocked wait
  a_r3_lock_before_dp: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_LOCK && !go_any && !lock_all) |=> !dp_rst);

  // R4: lock timeout re-enters the PLL reset
  a_r4_lock_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_LOCK && !go_any && !lock_all && chk_wait == CW'(LOCK_WAIT - 1))
      |=> pll_rst);

  // R5: datapath-only entry skips the PLL reset
  a_r5_dp_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (go_dp && !go_full) |=> (dp_rst && !pll_rst));

  // R7: completion needs every channel finished
  a_r7_all_channels: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_DP_DONE && !go_any && !ch_all_done) |=> !done_ctrl);

  // R8: any accepted request clears completion
  a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    go_any |=> !done_ctrl);

  // R11: full request wins over datapath-only
  a_r11_full_priority: assert property (@(posedge clk) disable iff (!rst_n)
    go_full |=> pll_rst);
endmodule

// File: rtl/xrs_done_sync.sv
module xrs_done_sync (
  input  logic usr_clk,
  input  logic rst_n,
  input  logic done_ctrl,
  output logic done_usr
);
  logic meta;

  always_ff @(posedge usr_clk or negedge rst_n) begin
    if (!rst_n) begin
      meta     <= 1'b0;
      done_usr <= 1'b0;
    end else begin
      meta     <= done_ctrl;
      done_usr <= meta;
    end
  end

  // R9: the output only follows the first synchronizer stage
  a_r9_two_stage: assert property (@(posedge usr_clk) disable iff (!rst_n)
    $rose(done_usr) |-> $past(meta));
endmodule

// File: rtl/xrs_dir_reset.sv
module xrs_dir_reset
  import xrs_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_PLL   = 2,
  parameter bit          IS_TX     = 1'b1,
  parameter int unsigned PLL_HOLD  = 8,
  parameter int unsigned LOCK_WAIT = 16,
  parameter int unsigned DP_HOLD   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_full_i,
  input  logic               req_dp_i,
  input  logic [NUM_PLL-1:0] pll_lock_i,
  input  logic [NUM_CH-1:0]  ch_rst_done_i,
  output logic [NUM_PLL-1:0] pll_rst_o,
  output logic [NUM_CH-1:0]  dp_rst_o,
  output logic [NUM_CH-1:0]  div_rst_o,
  input  logic               usr_clk,
  output logic               done_o
);
  logic       go_full, go_dp;
  logic       pll_rst, dp_rst, done_ctrl;
  seq_state_e state;

  xrs_req_sync i_sync_full (
    .clk(clk), .rst_n(rst_n), .req_async(req_full_i), .req_pulse(go_full)
  );
  xrs_req_sync i_sync_dp (
    .clk(clk), .rst_n(rst_n), .req_async(req_dp_i), .req_pulse(go_dp)
  );

  xrs_seq_fsm #(
    .PLL_HOLD(PLL_HOLD), .LOCK_WAIT(LOCK_WAIT), .DP_HOLD(DP_HOLD)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n), .go_full(go_full), .go_dp(go_dp),
    .lock_all(&pll_lock_i), .ch_all_done(&ch_rst_done_i),
    .state(state), .pll_rst(pll_rst), .dp_rst(dp_rst), .done_ctrl(done_ctrl)
  );

  assign pll_rst_o = {NUM_PLL{pll_rst}};
  assign dp_rst_o  = {NUM_CH{dp_rst}};

  generate
    if (IS_TX) begin : g_tx_div
      assign div_rst_o = {NUM_CH{dp_rst}};
    end else begin : g_rx_div
      assign div_rst_o = '0;
    end
  endgenerate

  xrs_done_sync i_done_sync (
    .usr_clk(usr_clk), .rst_n(rst_n), .done_ctrl(done_ctrl), .done_usr(done_o)
  );
endmodule

// File: tb/test_xrs_dir_reset.sv
module test_xrs_dir_reset;
  localparam int NCH = 4, NPLL = 2, PH = 8, LW = 16, DH = 4, LOCK_DLY = 5;
  localparam int MAXW = 1500;

  logic clk = 1'b0, usr_clk = 1'b0, rst_n = 1'b0;
  logic req_full = 1'b0, req_dp = 1'b0;
  logic [NPLL-1:0] lock;
  logic [NCH-1:0]  chd, hold_ch = '0;
  logic [NPLL-1:0] pll_rst, pll_rst_rx;
  logic [NCH-1:0]  dp_rst, div_rst, dp_rst_rx, div_rst_rx;
  logic            done, done_rx;

  always #10 clk = ~clk;      // 50 MHz control clock
  always #15 usr_clk = ~usr_clk;

  xrs_dir_reset #(.NUM_CH(NCH), .NUM_PLL(NPLL), .IS_TX(1'b1),
    .PLL_HOLD(PH), .LOCK_WAIT(LW), .DP_HOLD(DH)) i_xrs_dir_reset (
    .clk(clk), .rst_n(rst_n), .req_full_i(req_full), .req_dp_i(req_dp),
    .pll_lock_i(lock), .ch_rst_done_i(chd), .pll_rst_o(pll_rst),
    .dp_rst_o(dp_rst), .div_rst_o(div_rst), .usr_clk(usr_clk), .done_o(done));

  xrs_dir_reset #(.NUM_CH(NCH), .NUM_PLL(NPLL), .IS_TX(1'b0),
    .PLL_HOLD(PH), .LOCK_WAIT(LW), .DP_HOLD(DH)) i_xrs_dir_reset_rx (
    .clk(clk), .rst_n(rst_n), .req_full_i(req_full), .req_dp_i(req_dp),
    .pll_lock_i(lock), .ch_rst_done_i(chd), .pll_rst_o(pll_rst_rx),
    .dp_rst_o(dp_rst_rx), .div_rst_o(div_rst_rx), .usr_clk(usr_clk), .done_o(done_rx));

  // ---------------- stubs ----------------
  int lock_cnt = 0, pll_rises = 0, base_rises = 0, fail_target = 0;
  int ch_cnt [NCH];
  initial foreach (ch_cnt[i]) ch_cnt[i] = 0;

  always @(posedge clk) begin
    lock_cnt <= pll_rst[0] ? 0 : (lock_cnt < 255 ? lock_cnt + 1 : lock_cnt);
    for (int i = 0; i < NCH; i++)
      ch_cnt[i] <= dp_rst[i] ? 0 : (ch_cnt[i] < 255 ? ch_cnt[i] + 1 : ch_cnt[i]);
  end

  always_comb begin
    for (int i = 0; i < NPLL; i++)
      lock[i] = !pll_rst[i] && (lock_cnt >= LOCK_DLY) && ((pll_rises - base_rises) > fail_target);
    for (int i = 0; i < NCH; i++)
      chd[i] = (ch_cnt[i] >= 3 + 2 * i) && !hold_ch[i];
  end

  // ---------------- monitors (negedge) ----------------
  int pll_hi = 0, dp_hi = 0, dp_unlocked = 0, div_mismatch = 0, rx_div_bad = 0, rx_dp_seen = 0;
  int early_done = 0;
  bit in_full_seq = 1'b0;
  logic pll_q = 1'b0, dp_q = 1'b0;

  always @(negedge clk) begin
    if (pll_rst[0] && !pll_q) pll_rises++;
    if (pll_rst[0]) pll_hi++;
    if (dp_rst[0]) dp_hi++;
    if (dp_rst[0] && !dp_q && in_full_seq && !(&lock)) dp_unlocked++;
    if (div_rst != dp_rst) div_mismatch++;
    if (div_rst_rx != '0) rx_div_bad++;
    if (dp_rst_rx[0]) rx_dp_seen++;
    pll_q = pll_rst[0];
    dp_q  = dp_rst[0];
  end

  // ---------------- bookkeeping ----------------
  int n_tests = 0, n_fail = 0;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit full, input bit dp, input int len);
    @(negedge clk);
    req_full = full; req_dp = dp;
    repeat (len) @(negedge clk);
    req_full = 1'b0; req_dp = 1'b0;
  endtask

  // wait for done to fall (if high) then rise; returns cycles to rise or -1
  task automatic wait_done(output int cyc);
    int k;
    k = 0;
    while (done && k < MAXW) begin @(negedge clk); k++; end
    cyc = 0;
    while (!done && cyc < MAXW) begin @(negedge clk); cyc++; end
    if (cyc >= MAXW) cyc = -1;
  endtask

  // table: {is_full, fail count}
  typedef struct packed { logic full; logic [2:0] fails; } vec_t;
  localparam vec_t VEC [6] = '{
    '{1'b1, 3'd0}, '{1'b0, 3'd0}, '{1'b1, 3'd1},
    '{1'b1, 3'd2}, '{1'b0, 3'd0}, '{1'b1, 3'd0}
  };

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c, p0, ph0, dh0, lat;
    repeat (4) @(negedge clk);
    // R10: outputs during reset
    check("R10 pll_rst in reset", int'(pll_rst), 0);
    check("R10 dp/div in reset", int'({dp_rst, div_rst}), 0);
    check("R10 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R10 idle after reset", int'({pll_rst, dp_rst, done}), 0);

    // table-driven sequences
    foreach (VEC[v]) begin
      fail_target = VEC[v].fails;
      base_rises  = pll_rises;
      in_full_seq = VEC[v].full;
      p0 = pll_rises; ph0 = pll_hi; dh0 = dp_hi;
      pulse(VEC[v].full, !VEC[v].full, 3);
      wait_done(c);
      check($sformatf("R7 vec%0d completes", v), int'(c >= 0), 1);
      check($sformatf("R2 R4 vec%0d pll attempts", v), pll_rises - p0,
            VEC[v].full ? VEC[v].fails + 1 : 0);
      check($sformatf("R2 R5 vec%0d pll hold cycles", v), pll_hi - ph0,
            VEC[v].full ? PH * (VEC[v].fails + 1) : 0);
      check($sformatf("R5 vec%0d dp hold cycles", v), dp_hi - dh0, DH);
    end
    check("R3 dp reset never before lock", dp_unlocked, 0);
    check("R6 tx divider follows datapath", div_mismatch, 0);

    // R1: long held request = one sequence
    fail_target = 0; base_rises = pll_rises; in_full_seq = 1'b1;
    p0 = pll_rises;
    pulse(1'b1, 1'b0, 60);
    wait_done(c);
    check("R1 held request one attempt", pll_rises - p0, 1);

    // R11: simultaneous requests, full wins
    base_rises = pll_rises; p0 = pll_rises; ph0 = pll_hi;
    pulse(1'b1, 1'b1, 3);
    wait_done(c);
    check("R11 full wins attempts", pll_rises - p0, 1);
    check("R11 full wins hold", pll_hi - ph0, PH);

    // R8: done clears after a request, within sync latency
    base_rises = pll_rises;
    pulse(1'b1, 1'b0, 1);
    repeat (9) @(negedge clk);
    check("R8 done cleared after request", int'(done), 0);
    wait_done(c);

    // R7 + R8: stall one channel, restart mid-sequence
    hold_ch[NCH-1] = 1'b1;
    base_rises = pll_rises; p0 = pll_rises;
    pulse(1'b0, 1'b1, 2);
    while (!dp_rst[0]) @(negedge clk);
    while (dp_rst[0]) @(negedge clk);
    repeat (30) @(negedge clk);
    check("R7 done low with one channel pending", int'(done), 0);
    check("R7 dp-only no pll reset", pll_rises - p0, 0);
    pulse(1'b1, 1'b0, 2);
    repeat (4) @(negedge clk);
    check("R8 restart enters pll reset", int'(pll_rst[0]), 1);
    while (pll_rst[0]) @(negedge clk);
    while (!dp_rst[0]) @(negedge clk);
    while (dp_rst[0]) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R7 still low while channel held", int'(done), 0);
    hold_ch = '0;
    // R9: latency from all-channels-done to done_o
    lat = 0;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    check("R9 done latency lower bound", int'(lat >= 2), 1);
    check("R9 done latency upper bound", int'(lat <= 7), 1);
    check("R7 done high after release", int'(done), 1);

    // R6: receive variant
    check("R6 rx dividers never asserted", rx_div_bad, 0);
    check("R6 rx datapath reset exercised", int'(rx_dp_seen > 0), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule